// File: doc/BRIEF.md
# Two-Bit-per-Step SAR Conversion Controller with Range Clipping

This block sequences a successive-approximation conversion that settles two result bits per step. In each step it drives three reference codes to a reference generator, walks the reference capacitors through a fixed four-phase sequence, and reads three comparator outputs. Each output says whether the held analog value lies above one of the references. The count of references exceeded picks one quarter of the current search interval. The next step then splits that quarter into four again. After DW/2 steps the interval is one code wide, and its lower edge is the result.

An optional clipping mode puts a range check before the search. In the range check, the upper and lower references carry two programmable bound codes. A value above the upper bound, or below the lower bound, ends the conversion at once with a fixed saturated code. A value inside the bounds goes on to the full search. The analog reference generation and the comparators lie outside the block.

Top module: `sar2b_clip_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no start, busy, conv_done, cmp_err, result and all four phase outputs are 0.
- R2: While busy, exactly one phase output is high. Each step runs charge for CHARGE_LEN cycles, then wait, share and drain for one cycle each. While not busy, no phase output is high.
- R3: In the first search step, the references are ref_mid = 2^(DW-1), ref_up = 3·2^(DW-2) and ref_dn = 2^(DW-2). For DW=8 these are 128, 192 and 64.
- R4: cmp_above[0], cmp_above[1] and cmp_above[2] mean "above ref_mid", "above ref_up" and "above ref_dn". These bits are sampled in the share cycle. The count of set bits d (0..3) moves the interval base up by d quarters. The next references sit at base plus one, two and three new quarters, where a new quarter is one quarter of the old one.
- R5: With clipping off, a conversion takes DW/2 steps and the result is the final interval base. The first step decides result bits [DW-1:DW-2].
- R6: With clipping on, the first step is a range check. In that step ref_mid = 2^(DW-1), ref_up = the latched upper bound and ref_dn = the latched lower bound.
- R7: If cmp_above[1] is high in the range check, the conversion ends after that step with result 3·2^(DW-2)−1 (191 for DW=8). This case takes priority over R8.
- R8: Otherwise, if cmp_above[2] is low in the range check, the conversion ends after that step with result 2^(DW-2) (64 for DW=8).
- R9: If neither R7 nor R8 applies, the full DW/2-step search of R5 follows, so the conversion takes DW/2+1 steps.
- R10: In a search step, a comparator pattern that is not a thermometer ({up,mid,dn} not one of 000, 001, 011, 111) sets cmp_err. In the range check, up high with dn low also sets cmp_err. The decision is still the count of set bits. cmp_err stays set until the next accepted start.
- R11: conv_done is a one-cycle pulse, and result changes only with it. Clocked from the accepted start, conv_done comes (CHARGE_LEN+3) cycles per step later.
- R12: clip_en and the bounds are latched when a start is accepted while idle. Changes to them during a conversion, and start pulses while busy, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted only while idle) |
| clip_en | input | 1 | Select range-check (clipping) mode |
| bound_hi | input | DW | Upper clipping bound code |
| bound_lo | input | DW | Lower clipping bound code |
| cmp_above | input | 3 | Comparator outputs: [0] above ref_mid, [1] above ref_up, [2] above ref_dn |
| ref_mid | output | DW | Middle reference code |
| ref_up | output | DW | Upper reference code |
| ref_dn | output | DW | Lower reference code |
| ph_charge | output | 1 | Charge reference cells |
| ph_wait | output | 1 | Idle settling phase |
| ph_share | output | 1 | Charge-share to form references; comparators sampled |
| ph_drain | output | 1 | Discharge and reset capacitors |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle completion pulse |
| result | output | DW | Conversion result |
| cmp_err | output | 1 | Non-thermometer comparator pattern seen |

## Verification
The bench builds the block with DW=8 and CHARGE_LEN=2. At DW=8 a single run can convert every input code with clipping off, and again with bounds 200 and 60. That covers both ends of the scale, the values exactly at each bound and the codes one below each bound. CHARGE_LEN=2 exercises the multi-cycle charge count inside each step. It also fixes the step length at five cycles, so the latency of 20, 5 or 25 cycles shows whether a range check ended early or went on to a full search.

// File: rtl/sar2b_pkg.sv
// Shared types for the two-bit-per-step SAR controller.
package sar2b_pkg;
    // Phases of one conversion step, in sequence order.
    typedef enum logic [1:0] {
        PH_CHARGE = 2'd0,
        PH_WAIT   = 2'd1,
        PH_SHARE  = 2'd2,
        PH_DRAIN  = 2'd3
    } phase_e;
endpackage

// File: rtl/sar2b_phase_seq.sv
// Phase sequencer: cycles charge (CHARGE_LEN cycles), wait, share, drain.
// Assumes kick restarts a step at charge; the phase only advances while run.
module sar2b_phase_seq
    import sar2b_pkg::*;
#(
    parameter int CHARGE_LEN = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   kick,
    input  logic   run,
    output phase_e phase
);
    localparam int CW = (CHARGE_LEN > 1) ? $clog2(CHARGE_LEN) : 1;
    localparam logic [CW-1:0] CLAST = CW'(CHARGE_LEN - 1);

    logic [CW-1:0] cnt;

    // Advance the phase, holding charge for CHARGE_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CHARGE;
            cnt   <= '0;
        end else if (kick) begin
            phase <= PH_CHARGE;
            cnt   <= '0;
        end else if (run) begin
            case (phase)
                PH_CHARGE: begin
                    if (cnt == CLAST) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT:  phase <= PH_SHARE;
                PH_SHARE: phase <= PH_DRAIN;
                default:  phase <= PH_CHARGE;
            endcase
        end
    end

    // R2: wait is always followed by share unless a new start intervenes.
    p_wait_then_share_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !kick && phase == PH_WAIT) |=> (phase == PH_SHARE));
endmodule

// File: rtl/sar2b_thermo.sv
// Comparator decoder: counts references exceeded and checks that the
// pattern {up,mid,dn} is a thermometer code. Purely combinational.
module sar2b_thermo (
    input  logic [2:0] above,
    output logic [1:0] level,
    output logic       legal
);
    logic [2:0] t;

    // Order bits from highest to lowest reference, then count and validate.
    always_comb begin
        t     = {above[1], above[0], above[2]};
        legal = (t == 3'b000) || (t == 3'b001) || (t == 3'b011) || (t == 3'b111);
        level = {1'b0, above[0]} + {1'b0, above[1]} + {1'b0, above[2]};
    end
endmodule

// File: rtl/sar2b_refgen.sv
// Reference code generator: for a search step, places three references at
// one, two and three quarters of the current interval; for the range check,
// drives mid-scale and the two latched bounds. Assumes DW even and >= 4.
module sar2b_refgen #(
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic [DW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic          chk,
    input  logic [DW-1:0] lim_hi,
    input  logic [DW-1:0] lim_lo,
    output logic [DW-1:0] r_mid,
    output logic [DW-1:0] r_up,
    output logic [DW-1:0] r_dn,
    output logic [DW-1:0] quarter
);
    localparam int SHW = $clog2(DW);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [SHW-1:0] shamt;

    // Quarter width for this step and the three reference codes.
    always_comb begin
        shamt   = SHW'(DW - 2) - SHW'(2 * int'(step));
        quarter = {{(DW-1){1'b0}}, 1'b1} << shamt;
        if (chk) begin
            r_mid = MID;
            r_up  = lim_hi;
            r_dn  = lim_lo;
        end else begin
            r_mid = base + (quarter << 1);
            r_up  = base + (quarter << 1) + quarter;
            r_dn  = base + quarter;
        end
    end
endmodule

// File: rtl/sar2b_clip_ctrl.sv
// Two-bit-per-step SAR controller with optional range clipping.
// Assumes comparators are valid in the share cycle and that bound_hi/lo
// and clip_en are meaningful when start is accepted while idle.
module sar2b_clip_ctrl
    import sar2b_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CHARGE_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clip_en,
    input  logic [DW-1:0] bound_hi,
    input  logic [DW-1:0] bound_lo,
    input  logic [2:0]    cmp_above,
    output logic [DW-1:0] ref_mid,
    output logic [DW-1:0] ref_up,
    output logic [DW-1:0] ref_dn,
    output logic          ph_charge,
    output logic          ph_wait,
    output logic          ph_share,
    output logic          ph_drain,
    output logic          busy,
    output logic          conv_done,
    output logic [DW-1:0] result,
    output logic          cmp_err
);
    localparam int STEPS = DW / 2;
    localparam int SW    = $clog2(STEPS);
    localparam logic [SW-1:0] LAST    = SW'(STEPS - 1);
    localparam logic [DW-1:0] CLIP_HI = {2'b10, {(DW-2){1'b1}}};
    localparam logic [DW-1:0] CLIP_LO = {2'b01, {(DW-2){1'b0}}};

    phase_e        phase;
    logic          kick;
    logic [SW-1:0] step;
    logic          chk;
    logic          clip_q;
    logic [DW-1:0] hi_q, lo_q;
    logic [DW-1:0] base, nxt_base, quarter;
    logic          fin;
    logic [DW-1:0] fin_code;
    logic [1:0]    level;
    logic          legal;

    assign kick = start && !busy;

    sar2b_phase_seq #(.CHARGE_LEN(CHARGE_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .kick(kick), .run(busy), .phase(phase)
    );

    sar2b_thermo u_thermo (.above(cmp_above), .level(level), .legal(legal));

    sar2b_refgen #(.DW(DW), .SW(SW)) u_ref (
        .base(base), .step(step), .chk(chk), .lim_hi(hi_q), .lim_lo(lo_q),
        .r_mid(ref_mid), .r_up(ref_up), .r_dn(ref_dn), .quarter(quarter)
    );

    // Decode the phase outputs, gated by busy.
    always_comb begin
        ph_charge = busy && (phase == PH_CHARGE);
        ph_wait   = busy && (phase == PH_WAIT);
        ph_share  = busy && (phase == PH_SHARE);
        ph_drain  = busy && (phase == PH_DRAIN);
    end

    // Base of the selected quarter after this step's decision.
    always_comb begin
        nxt_base = base + (level[1] ? (quarter << 1) : '0) + (level[0] ? quarter : '0);
    end

    // Conversion control: latch settings, take decisions, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            conv_done <= 1'b0;
            result    <= '0;
            cmp_err   <= 1'b0;
            step      <= '0;
            chk       <= 1'b0;
            clip_q    <= 1'b0;
            hi_q      <= '0;
            lo_q      <= '0;
            base      <= '0;
            fin       <= 1'b0;
            fin_code  <= '0;
        end else begin
            conv_done <= 1'b0;
            if (kick) begin
                busy    <= 1'b1;
                step    <= '0;
                base    <= '0;
                chk     <= clip_en;
                clip_q  <= clip_en;
                hi_q    <= bound_hi;
                lo_q    <= bound_lo;
                cmp_err <= 1'b0;
                fin     <= 1'b0;
            end else if (busy) begin
                if (phase == PH_SHARE) begin
                    if (chk) begin
                        if (cmp_above[1] && !cmp_above[2]) cmp_err <= 1'b1;
                        if (cmp_above[1]) begin
                            fin      <= 1'b1;
                            fin_code <= CLIP_HI;
                        end else if (!cmp_above[2]) begin
                            fin      <= 1'b1;
                            fin_code <= CLIP_LO;
                        end
                    end else begin
                        if (!legal) cmp_err <= 1'b1;
                        base <= nxt_base;
                        if (step == LAST) begin
                            fin      <= 1'b1;
                            fin_code <= nxt_base;
                        end
                    end
                end else if (phase == PH_DRAIN) begin
                    if (fin) begin
                        busy      <= 1'b0;
                        conv_done <= 1'b1;
                        result    <= fin_code;
                    end else if (chk) begin
                        chk <= 1'b0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            end
        end
    end

    // R2: one phase at a time while converting, none while idle.
    p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot({ph_charge, ph_wait, ph_share, ph_drain}));
    p_phase_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({ph_charge, ph_wait, ph_share, ph_drain} == 4'b0000));
    // R4: search references are strictly ordered during share.
    p_ref_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_share && !chk) |-> (ref_dn < ref_mid && ref_mid < ref_up));
    // R7/R8: a conversion ending in the first step of clip mode is saturated.
    p_clip_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && clip_q && step == '0) |-> (result == CLIP_HI || result == CLIP_LO));
    // R10: the error flag holds until a new start is accepted.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_err && !kick) |=> cmp_err);
    // R11: completion is a single-cycle pulse.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);
    // R11: the result only changes together with the completion pulse.
    p_result_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> conv_done);
endmodule

// File: tb/tb_sar2b_clip_ctrl.sv
// Scoreboard bench: the driver pushes expected outcomes, the monitor pops
// and compares them when a conversion completes.
module tb_sar2b_clip_ctrl;
    localparam int DW = 8;
    localparam int CL = 2;
    localparam int SLEN = CL + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          clip_en = 1'b0;
    logic [DW-1:0] bound_hi = '0;
    logic [DW-1:0] bound_lo = '0;
    logic [2:0]    cmp_above;
    logic [DW-1:0] ref_mid, ref_up, ref_dn, result;
    logic          ph_charge, ph_wait, ph_share, ph_drain;
    logic          busy, conv_done, cmp_err;

    int       vin = 0;
    logic [2:0] flip = 3'b000;
    int       nchk = 0;
    int       nerr = 0;
    int       ndone = 0;

    typedef struct {
        int    res;
        bit    err;
        int    lat;
        int    r1;
        int    r2;
        int    r3;
        string tag;
        string rtag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    // Behavioural comparators: the analog value is vin + 0.5 LSB.
    assign cmp_above = {(vin >= int'(ref_dn)), (vin >= int'(ref_up)), (vin >= int'(ref_mid))} ^ flip;

    sar2b_clip_ctrl #(.DW(DW), .CHARGE_LEN(CL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clip_en(clip_en),
        .bound_hi(bound_hi), .bound_lo(bound_lo), .cmp_above(cmp_above),
        .ref_mid(ref_mid), .ref_up(ref_up), .ref_dn(ref_dn),
        .ph_charge(ph_charge), .ph_wait(ph_wait), .ph_share(ph_share),
        .ph_drain(ph_drain), .busy(busy), .conv_done(conv_done),
        .result(result), .cmp_err(cmp_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outcome computed from the requirements.
    function automatic exp_t model(input int v, input bit clip, input int hi, input int lo,
                                   input logic [2:0] fl);
        exp_t e;
        int base;
        int q;
        bit a1, a2, a3;
        e.err = 0; e.r1 = 128; e.tag = ""; e.rtag = "";
        if (clip) begin
            e.r2 = hi; e.r3 = lo;
            a2 = (v >= hi) ^ fl[1];
            a3 = (v >= lo) ^ fl[2];
            if (a2 && !a3) e.err = 1;
            if (a2) begin e.res = 191; e.lat = SLEN; return e; end
            if (!a3) begin e.res = 64; e.lat = SLEN; return e; end
        end else begin
            e.r2 = 192; e.r3 = 64;
        end
        base = 0;
        for (int s = 0; s < 4; s++) begin
            q  = 64 >> (2 * s);
            a1 = (v >= base + 2 * q) ^ fl[0];
            a2 = (v >= base + 3 * q) ^ fl[1];
            a3 = (v >= base + q) ^ fl[2];
            if ((a2 && !a1) || (a1 && !a3)) e.err = 1;
            base = base + (int'(a1) + int'(a2) + int'(a3)) * q;
        end
        e.res = base;
        e.lat = clip ? 5 * SLEN : 4 * SLEN;
        return e;
    endfunction

    // Driver: set stimulus, push the expectation, pulse start, await completion.
    // mode 1 disturbs the latched settings, mode 2 adds a start while busy.
    task automatic run(input int v, input bit clip, input int hi, input int lo,
                       input logic [2:0] fl, input int mode, input string tag, input string rtag);
        exp_t e;
        int target;
        @(negedge clk);
        vin = v; flip = fl; clip_en = clip;
        bound_hi = DW'(hi); bound_lo = DW'(lo);
        e = model(v, clip, hi, lo, fl);
        e.tag = tag; e.rtag = rtag;
        sb.push_back(e);
        target = ndone + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mode == 1) begin
            bound_hi = 8'd5; bound_lo = 8'd250; clip_en = ~clip;
        end
        if (mode == 2) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (ndone == target);
    endtask

    // Monitor: track phases and first-step references, compare at completion.
    int  lat = 0;
    bit  phase_bad = 0;
    int  c1 = 0, c2 = 0, c3 = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                int pos;
                logic [3:0] ev;
                lat++;
                pos = (lat - 1) % SLEN;
                ev = (pos < CL) ? 4'b1000 : (pos == CL) ? 4'b0100 :
                     (pos == CL + 1) ? 4'b0010 : 4'b0001;
                if ({ph_charge, ph_wait, ph_share, ph_drain} != ev) phase_bad = 1;
                if (lat == CL + 2) begin
                    c1 = int'(ref_mid); c2 = int'(ref_up); c3 = int'(ref_dn);
                end
            end else if (conv_done) begin
                if (sb.size() == 0) begin
                    check(0, "R11 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(result) == e.res, {e.tag, " result"}, int'(result), e.res);
                    check(cmp_err == e.err, {e.tag, " R10 error flag"}, int'(cmp_err), int'(e.err));
                    check(lat == e.lat, {e.tag, " R11 latency"}, lat, e.lat);
                    check(c1 == e.r1 && c2 == e.r2 && c3 == e.r3, {e.rtag, " first-step references"},
                          c1 * 65536 + c2 * 256 + c3, e.r1 * 65536 + e.r2 * 256 + e.r3);
                    check(!phase_bad, "R2 phase sequence", int'(phase_bad), 0);
                end
                lat = 0;
                phase_bad = 0;
                ndone++;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        bit stable_ok;
        bit done_seen;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(!busy && !conv_done && !cmp_err, "R1 control outputs in reset",
              int'({busy, conv_done, cmp_err}), 0);
        check(result == '0, "R1 result in reset", int'(result), 0);
        check({ph_charge, ph_wait, ph_share, ph_drain} == 4'b0, "R1 phases in reset",
              int'({ph_charge, ph_wait, ph_share, ph_drain}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !conv_done && {ph_charge, ph_wait, ph_share, ph_drain} == 4'b0,
              "R1 R2 idle after reset", int'({busy, conv_done, ph_charge, ph_wait, ph_share, ph_drain}), 0);

        // R3 R4 R5: every code without clipping
        for (int v = 0; v < 256; v++) run(v, 1'b0, 0, 0, 3'b000, 0, "R4 R5 normal", "R3");

        // R6 R7 R8 R9: every code with bounds 200 / 60 (boundaries at 199/200 and 59/60)
        for (int v = 0; v < 256; v++) run(v, 1'b1, 200, 60, 3'b000, 0, "R7 R8 R9 clip", "R6");

        // R7 R8 with other bounds
        run(255, 1'b1, 255, 0, 3'b000, 0, "R7 top bound", "R6");
        run(0, 1'b1, 255, 1, 3'b000, 0, "R8 bottom bound", "R6");

        // R10: forced non-thermometer patterns
        run(0, 1'b0, 0, 0, 3'b010, 0, "R10 invalid search pattern", "R3");
        run(180, 1'b0, 0, 0, 3'b001, 0, "R10 invalid mid bit", "R3");
        run(100, 1'b1, 200, 60, 3'b110, 0, "R10 R7 clip up without dn", "R6");

        // R10: error flag cleared by the next start
        run(77, 1'b0, 0, 0, 3'b000, 0, "R10 cleared on restart", "R3");

        // R12: settings changed during conversion are ignored
        run(100, 1'b1, 200, 60, 3'b000, 1, "R12 settings latched", "R12");
        run(230, 1'b1, 200, 60, 3'b000, 1, "R12 settings latched high", "R12");
        run(150, 1'b0, 0, 0, 3'b000, 1, "R12 clip_en latched", "R12");
        // R12: extra start while busy is ignored
        run(42, 1'b0, 0, 0, 3'b000, 2, "R12 start while busy", "R3");

        // R11: single pulse and held result
        held = result;
        stable_ok = 1;
        done_seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (result != held) stable_ok = 0;
            if (conv_done) done_seen = 1;
        end
        check(stable_ok, "R11 result held after completion", int'(result), int'(held));
        check(!done_seen, "R11 completion is a single pulse", int'(done_seen), 0);
        check(sb.size() == 0, "R11 all expected completions seen", sb.size(), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule